// File: doc/BRIEF.md
# Sampling Converter Parallel Control Interface

This block is the digital front of an eight-channel, 12-bit sampling converter that sits on a shared parallel bus. A host writes a small control word over the bus to pick the input channel, to request software-started conversions, to park the converter in standby and to choose the output coding. A host read returns the latest conversion result in the selected coding.

The bus is presented as split pad signals (`bus_in`, `bus_out`, `bus_oe`) so that a three-state pad can be placed at the chip edge. The active-low strobes are registered into the system clock domain once. Releasing the write strobe arms a settling timer, which gives the channel multiplexer and the track/hold time to settle. When the timer expires with the start flag set and standby clear, a behavioural conversion engine captures `raw_sample` and produces the result after a fixed number of cycles.

Top module: `smpl_par_if`

## Requirements
- R1: After reset the control word is zero: `chan_sel` is 0, `busy` is 0, `bus_oe` is 0, and the result register is 0, so the first read returns 12'h000 in straight binary.
- R2: `bus_oe` is 1 exactly one clock after `par_mode` is 1 and `cs_n` and `rd_n` are both 0 at a rising edge. At every other time `bus_oe` is 0. While `bus_oe` is 1, `bus_out` carries the result.
- R3: A write loads the control word from `bus_in` while `par_mode` is 1 and `cs_n` and `wr_n` are both 0. The field positions are: bits 2:0 the channel, bit 3 the start flag, bit 4 standby, bit 5 format. Bits 11:6 are ignored. `chan_sel` shows the channel field.
- R4: While `par_mode` is 0, writes leave the control word unchanged and reads leave `bus_oe` at 0.
- R5: Suppose the start flag is 1 and standby is 0 after a write. `busy` then rises on the (SETTLE+2)-th rising clock edge after `wr_n` returns high, and not earlier.
- R6: A new write before the settling time expires restarts the count from the later write's release.
- R7: If the start flag is 0, a write never starts a conversion.
- R8: While standby is 1, no conversion starts. A write that sets standby discards a settling pulse that is already pending.
- R9: `busy` stays high for exactly CONV cycles. `raw_sample` is captured on the edge where `busy` rises, and the result register takes that value when `busy` falls.
- R10: With format 1 the read value is the result with its MSB inverted (twos complement). With format 0 it is the straight-binary result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_mode | input | 1 | 1 selects parallel bus operation |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_in | input | 12 | Data bus value from the pad |
| bus_out | output | 12 | Data bus value to the pad |
| bus_oe | output | 1 | Pad output enable |
| raw_sample | input | 12 | Behavioural sample of the selected channel |
| chan_sel | output | 3 | Multiplexer channel address |
| busy | output | 1 | Conversion in progress |

## Verification
The assertions assume that the strobes change only between clock edges and that they hold for at least one full cycle. They also assume that a read and a write are never asserted together. With those assumptions, one registered sample of each strobe gives a clean edge. The bench drives every input on the falling clock edge. Each write holds `cs_n` and `wr_n` low for two cycles, and a read is never overlapped with a write. The random control words, modes and samples therefore stay inside these assumptions. Conversions are also allowed to finish before the next write, so the start check in the model is never hidden by a conversion that is still running.

// File: rtl/smpl_pkg.sv
package smpl_pkg;
  localparam int unsigned CH_W   = 3;
  localparam int unsigned CTRL_W = CH_W + 3;

  // Field order matches the bus bit positions: channel in the low bits.
  typedef struct packed {
    logic            fmt;    // bit 5: 1 = twos complement
    logic            stby;   // bit 4: standby
    logic            swcon;  // bit 3: software start
    logic [CH_W-1:0] chan;   // bits 2:0
  } ctrl_t;
endpackage

// File: rtl/smpl_bus_sync.sv
module smpl_bus_sync #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          par_mode,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_in,
  output logic          wr_act,
  output logic          wr_done,
  output logic          rd_act,
  output logic [DW-1:0] data_q
);
  logic mode_q, cs_q, rd_q, wr_q, wr_act_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= 1'b0;
      cs_q        <= 1'b1;
      rd_q        <= 1'b1;
      wr_q        <= 1'b1;
      data_q      <= '0;
      wr_act_prev <= 1'b0;
    end else begin
      mode_q      <= par_mode;
      cs_q        <= cs_n;
      rd_q        <= rd_n;
      wr_q        <= wr_n;
      data_q      <= bus_in;
      wr_act_prev <= wr_act;
    end
  end

  assign wr_act  = mode_q & ~cs_q & ~wr_q;
  assign rd_act  = mode_q & ~cs_q & ~rd_q;
  assign wr_done = wr_act_prev & ~wr_act;
endmodule

// File: rtl/smpl_settle.sv
module smpl_settle #(
  parameter int unsigned SETTLE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic kill,
  output logic expire
);
  localparam int unsigned CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || kill)      cnt <= '0;
    else if (arm)         cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - ONE;
  end

  assign expire = (cnt == ONE) && !arm && !kill;
endmodule

// File: rtl/smpl_conv.sv
module smpl_conv #(
  parameter int unsigned DW   = 12,
  parameter int unsigned CONV = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] sample,
  output logic          busy,
  output logic [DW-1:0] result
);
  localparam int unsigned CW = (CONV > 1) ? $clog2(CONV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] ccnt;
  logic [DW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      ccnt   <= '0;
      held   <= '0;
      result <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        ccnt <= LAST;
        held <= sample;
      end
    end else if (ccnt == '0) begin
      busy   <= 1'b0;
      result <= held;
    end else begin
      ccnt <= ccnt - ONE;
    end
  end
endmodule

// File: rtl/smpl_par_if.sv
module smpl_par_if #(
  parameter int unsigned DW     = 12,
  parameter int unsigned SETTLE = 16,
  parameter int unsigned CONV   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      par_mode,
  input  logic                      cs_n,
  input  logic                      rd_n,
  input  logic                      wr_n,
  input  logic [DW-1:0]             bus_in,
  output logic [DW-1:0]             bus_out,
  output logic                      bus_oe,
  input  logic [DW-1:0]             raw_sample,
  output logic [smpl_pkg::CH_W-1:0] chan_sel,
  output logic                      busy
);
  import smpl_pkg::*;

  logic          wr_act, wr_done, rd_act, expire, start;
  logic [DW-1:0] data_q, result;
  ctrl_t         ctrl_q;

  smpl_bus_sync #(.DW(DW)) u_sync (
    .clk(clk), .rst(rst), .par_mode(par_mode), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .bus_in(bus_in), .wr_act(wr_act), .wr_done(wr_done),
    .rd_act(rd_act), .data_q(data_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '0;
    else if (wr_act) ctrl_q <= ctrl_t'(data_q[CTRL_W-1:0]);
  end

  smpl_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst(rst), .arm(wr_done), .kill(ctrl_q.stby), .expire(expire)
  );

  assign start = expire & ctrl_q.swcon & ~ctrl_q.stby;

  smpl_conv #(.DW(DW), .CONV(CONV)) u_conv (
    .clk(clk), .rst(rst), .start(start), .sample(raw_sample),
    .busy(busy), .result(result)
  );

  assign bus_oe   = rd_act;
  assign bus_out  = ctrl_q.fmt ? {~result[DW-1], result[DW-2:0]} : result;
  assign chan_sel = ctrl_q.chan;
endmodule

// File: rtl/smpl_par_if_chk.sv
module smpl_par_if_chk #(
  parameter int unsigned CONV = 8,
  parameter int unsigned CH_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            par_mode,
  input logic            cs_n,
  input logic            rd_n,
  input logic            bus_oe,
  input logic            busy,
  input logic            swcon,
  input logic            stby,
  input logic [CH_W-1:0] chan_sel
);
  localparam int unsigned BW = $clog2(CONV + 2);
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + BW'(1);
    else           bcnt <= '0;
  end

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(par_mode && !cs_n && !rd_n)); // R2

  AST_CTRL_HELD_SERIAL: assert property (@(posedge clk) disable iff (rst)
    !$past(par_mode, 2) |-> $stable(chan_sel)); // R4

  AST_START_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(swcon)); // R7

  AST_NO_START_STANDBY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(stby)); // R8

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == BW'(CONV))); // R9

  AST_BUSY_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt < BW'(CONV))); // R9
endmodule

bind smpl_par_if smpl_par_if_chk #(.CONV(CONV), .CH_W(smpl_pkg::CH_W)) u_chk (
  .clk(clk), .rst(rst), .par_mode(par_mode), .cs_n(cs_n), .rd_n(rd_n),
  .bus_oe(bus_oe), .busy(busy), .swcon(ctrl_q.swcon), .stby(ctrl_q.stby),
  .chan_sel(chan_sel)
);

// File: tb/smpl_par_if_test.sv
module smpl_par_if_test;
  localparam int unsigned DW = 12, SETTLE = 16, CONV = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic par_mode = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [DW-1:0] bus_in = '0, raw_sample = '0, bus_out;
  logic bus_oe, busy;
  logic [2:0] chan_sel;

  int vectors = 0, errors = 0;
  logic [5:0]    exp_ctrl = '0;
  logic [DW-1:0] exp_res  = '0;
  bit done = 0;

  always #5 clk = ~clk;

  smpl_par_if #(.DW(DW), .SETTLE(SETTLE), .CONV(CONV)) uut (
    .clk(clk), .rst(rst), .par_mode(par_mode), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .raw_sample(raw_sample), .chan_sel(chan_sel), .busy(busy)
  );

  function automatic logic [DW-1:0] coded(input logic [DW-1:0] r, input logic fmt);
    return fmt ? (r ^ (1 << (DW - 1))) : r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [DW-1:0] v, input logic m);
    @(negedge clk); par_mode = m; bus_in = v; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    if (m) exp_ctrl = v[5:0];
  endtask

  task automatic do_read(input logic m, output logic [DW-1:0] v, output logic oe);
    @(negedge clk); par_mode = m; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); v = bus_out; oe = bus_oe; cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  // Called right after do_write returns; checks timing of a started conversion.
  task automatic expect_conv(input string req);
    logic [DW-1:0] s;
    s = raw_sample;
    repeat (SETTLE + 1) @(negedge clk);
    check({req, " busy before settle"}, busy, 1'b0);
    @(negedge clk);
    check({req, " busy at settle"}, busy, 1'b1);
    raw_sample = DW'($urandom);  // R9: change after capture must not matter
    repeat (CONV - 1) @(negedge clk);
    check("R9 busy held", busy, 1'b1);
    @(negedge clk);
    check("R9 busy fell", busy, 1'b0);
    exp_res = s;
  endtask

  task automatic expect_idle(input string req);
    repeat (SETTLE + CONV + 4) begin
      @(negedge clk);
      if (busy) break;
    end
    check(req, busy, 1'b0);
  endtask

  task automatic read_check(input string req);
    logic [DW-1:0] v; logic oe;
    do_read(1'b1, v, oe);
    check({req, " oe"}, oe, 1'b1);
    check({req, " data"}, v, coded(exp_res, exp_ctrl[5]));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] v; logic oe;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 chan_sel", chan_sel, 3'd0);
    check("R1 busy", busy, 1'b0);
    check("R1 bus_oe", bus_oe, 1'b0);
    read_check("R1 R2 first read");

    // R4 serial mode: write ignored, read not driven
    do_write(12'hFFF, 1'b0);
    check("R4 chan_sel unchanged", chan_sel, 3'd0);
    expect_idle("R4 no conversion");
    do_read(1'b0, v, oe);
    check("R4 oe low", oe, 1'b0);

    // R3 R5 R9 R10 directed conversion, twos complement
    raw_sample = 12'h123;
    do_write(12'hFC_5 | 12'h02A, 1'b1); // bits 5:0 = 6'b101111 -> fmt1 swcon1 chan7
    check("R3 chan_sel", chan_sel, 3'd7);
    expect_conv("R5");
    read_check("R10 twos complement");

    // R6 restart: second write mid-settle
    raw_sample = 12'hA5A;
    do_write(12'h008, 1'b1);
    repeat (5) @(negedge clk);
    do_write(12'h00A, 1'b1);
    check("R6 chan_sel", chan_sel, 3'd2);
    expect_conv("R6");
    read_check("R10 straight binary");

    // R7 start flag clear
    raw_sample = 12'h777;
    do_write(12'h003, 1'b1);
    expect_idle("R7 no conversion");
    read_check("R7 result kept");

    // R8 standby discards a pending pulse
    do_write(12'h008, 1'b1);
    repeat (4) @(negedge clk);
    do_write(12'h018, 1'b1);
    expect_idle("R8 pending discarded");
    do_write(12'h000, 1'b1);

    // Random mix
    for (int i = 0; i < 60; i++) begin
      logic [DW-1:0] w; logic m;
      raw_sample = DW'($urandom);
      w = DW'($urandom);
      m = ($urandom % 4) != 0;
      do_write(w, m);
      check("R3 R4 random chan_sel", chan_sel, exp_ctrl[2:0]);
      if (m && w[3] && !w[4]) expect_conv("R5 random");
      else                    expect_idle("R7 R8 random idle");
      read_check("R2 R10 random read");
    end

    done = 1;
    finish_run();
  end
endmodule